// File: doc/BRIEF.md
# Memory Access Alignment Checker

This block watches every data memory reference that a processor core issues. It raises an alignment fault when the reference's address does not fall on the boundary that its data type requires. The core supplies a few inputs with each request: a valid strobe, the linear address, a 4-bit data-type code, the operand-size attribute and the current privilege level. It also supplies a flag that marks the reference as an implicit supervisor access, and the alignment-check enable bit. The block answers one cycle later with a single-cycle fault strobe, the exception vector number and the error code.

Checking is active only when the enable bit is set and the reference runs at privilege level 3. Implicit supervisor references are always exempt. These include descriptor-table reads during selector loads and task-state accesses. The block looks only at the low three address bits. Address translation, exception delivery and instruction decode belong to other blocks.

Top module: `align_fault_unit`

## Requirements
- R1: When `align_en` is 0, `fault_pulse` never asserts, whatever the other inputs are.
- R2: A reference with `cpl` of 0, 1 or 2 never faults. Only `cpl` = 3 can fault.
- R3: A reference with `sys_access` = 1 never faults, even at `cpl` = 3.
- R4: Type codes 1 (word), 2 (selector) and 3 (32-bit segmented pointer) need a 2-byte boundary. They fault when `req_addr[0]` is 1.
- R5: Type codes 4 (dword), 5 (single real), 6 (48-bit segmented pointer), 7 (32-bit flat pointer), 8 (pseudo-descriptor) and 9 (bit string) need a 4-byte boundary. They fault when `req_addr[1:0]` is not 0.
- R6: Type codes 10 (double real) and 11 (extended real) need an 8-byte boundary. They fault when `req_addr[2:0]` is not 0.
- R7: Type codes 12 (environment save area) and 13 (full FPU state save area) need a 4-byte boundary when `opsize32` = 1 and a 2-byte boundary when `opsize32` = 0.
- R8: Type code 0 (byte) and the unused codes 14 and 15 never fault.
- R9: `fault_pulse` is registered. It is high for exactly the one cycle after a faulting request. It is low after any cycle in which `req_valid` is 0.
- R10: While `fault_pulse` is high, `fault_vector` is 17 and `fault_code` is 0. While it is low, both outputs are 0.
- R11: A synchronous active-high `rst` clears `fault_pulse`, `fault_vector` and `fault_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A reference is presented this cycle |
| req_addr | input | ADDR_W | Linear address of the reference |
| req_type | input | 4 | Data-type code |
| opsize32 | input | 1 | 1 for 32-bit operand size, 0 for 16-bit |
| cpl | input | 2 | Current privilege level |
| sys_access | input | 1 | Implicit supervisor reference, exempt from checking |
| align_en | input | 1 | Alignment-check enable |
| fault_pulse | output | 1 | One-cycle alignment fault strobe |
| fault_vector | output | VEC_W | Exception vector, 17 on fault |
| fault_code | output | CODE_W | Error code, 0 |

## Verification
The bench sweeps every type code against every low-address residue at both operand sizes. This sweep catches a type placed in the wrong boundary class. Such a design would fault a selector on a 2-mod-4 address, or pass an extended real at address 4. The sweep also catches save areas that ignore operand size, which would fault at 2-byte-aligned addresses in 16-bit mode. The bench also exercises the gates one at a time: enable off, levels 0 to 2, implicit supervisor references and invalid strobes. A design that leaked any of these gates would show a fault where none belongs. Back-to-back faulting requests, and a fault followed by idle, expose a strobe that stretches or is dropped. A reset in the cycle after a faulting request shows whether reset truly overrides a fault.

// File: rtl/align_fault_unit.sv
module align_fault_unit #(
  parameter int ADDR_W       = 32,
  parameter int VEC_W        = 8,
  parameter int CODE_W       = 32,
  parameter int FAULT_VECTOR = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_type,
  input  logic              opsize32,
  input  logic [1:0]        cpl,
  input  logic              sys_access,
  input  logic              align_en,
  output logic              fault_pulse,
  output logic [VEC_W-1:0]  fault_vector,
  output logic [CODE_W-1:0] fault_code
);

  logic [2:0] low_mask;
  logic       checking;
  logic       misaligned;
  logic       fault_q;
  logic       unused_hi;

  assign unused_hi = ^req_addr[ADDR_W-1:3];

  always_comb begin
    case (req_type)
      4'd1, 4'd2, 4'd3:                     low_mask = 3'b001;
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:   low_mask = 3'b011;
      4'd10, 4'd11:                         low_mask = 3'b111;
      4'd12, 4'd13:                         low_mask = opsize32 ? 3'b011 : 3'b001;
      default:                              low_mask = 3'b000;
    endcase
  end

  assign checking   = req_valid && align_en && (cpl == 2'd3) && !sys_access;
  assign misaligned = |(req_addr[2:0] & low_mask);

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= checking && misaligned;
  end

  assign fault_pulse  = fault_q;
  assign fault_vector = fault_q ? VEC_W'(FAULT_VECTOR) : '0;
  assign fault_code   = '0;

  AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
    !align_en |=> !fault_pulse); // R1
  AST_PRIV_GATE: assert property (@(posedge clk) disable iff (rst)
    (cpl != 2'd3) |=> !fault_pulse); // R2
  AST_SYS_EXEMPT: assert property (@(posedge clk) disable iff (rst)
    sys_access |=> !fault_pulse); // R3
  AST_WORD_ODD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && align_en && cpl == 2'd3 && !sys_access && req_type == 4'd1 && req_addr[0])
      |=> fault_pulse); // R4
  AST_QWORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ((req_type == 4'd10 || req_type == 4'd11) && req_addr[2:0] == 3'd0) |=> !fault_pulse); // R6
  AST_BYTE_NEVER: assert property (@(posedge clk) disable iff (rst)
    (req_type == 4'd0 || req_type >= 4'd14) |=> !fault_pulse); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !fault_pulse); // R9
  AST_VEC_VALUE: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> (fault_vector == VEC_W'(FAULT_VECTOR) && fault_code == '0)); // R10
  AST_VEC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fault_pulse |-> (fault_vector == '0 && fault_code == '0)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !fault_pulse); // R11

endmodule

// File: tb/align_fault_unit_bench.sv
module align_fault_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_type = '0;
  logic        opsize32 = 1'b1;
  logic [1:0]  cpl = 2'd3;
  logic        sys_access = 1'b0;
  logic        align_en = 1'b1;
  logic        fault_pulse;
  logic [7:0]  fault_vector;
  logic [31:0] fault_code;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    stamp;
    bit    flt;
    string tag;
  } exp_t;
  exp_t sb[$];

  align_fault_unit u_align_fault_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_type(req_type), .opsize32(opsize32), .cpl(cpl),
    .sys_access(sys_access), .align_en(align_en),
    .fault_pulse(fault_pulse), .fault_vector(fault_vector), .fault_code(fault_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int boundary(input logic [3:0] t, input logic o32);
    if (t >= 4'd1 && t <= 4'd3) return 2;
    if (t >= 4'd4 && t <= 4'd9) return 4;
    if (t == 4'd10 || t == 4'd11) return 8;
    if (t == 4'd12 || t == 4'd13) return o32 ? 4 : 2;
    return 1;
  endfunction

  task automatic compare(input bit ef, input string tag);
    logic [7:0] ev;
    ev = ef ? 8'd17 : 8'd0;
    checks++;
    if (fault_pulse !== ef || fault_vector !== ev || fault_code !== 32'd0) begin
      fails++;
      $display("FAIL %s: pulse=%0b vec=%0d code=%0d expected pulse=%0b vec=%0d code=0",
               tag, fault_pulse, fault_vector, fault_code, ef, ev);
    end
  endtask

  task automatic drive(input bit v, input logic [31:0] a, input logic [3:0] t,
                       input bit o32, input logic [1:0] pl, input bit sys,
                       input bit en, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_addr = a; req_type = t; opsize32 = o32;
    cpl = pl; sys_access = sys; align_en = en;
    e.stamp = cyc;
    e.flt = v && en && (pl == 2'd3) && !sys && ((a % boundary(t, o32)) != 0);
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && sb.size() > 0 && sb[0].stamp < cyc) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.flt, e.tag);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b1; req_addr = 32'h1; req_type = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(1'b0, "R11 reset state");
    rst = 1'b0;
    req_valid = 1'b0;

    drive(1, 32'h1001, 4'd1, 1, 3, 0, 1, "R4 word odd");
    drive(1, 32'h1002, 4'd1, 1, 3, 0, 1, "R4 word even");
    drive(1, 32'h0003, 4'd2, 1, 3, 0, 1, "R4 selector odd");
    drive(1, 32'h0006, 4'd3, 1, 3, 0, 1, "R4 segptr32 at 2 mod 4");
    drive(1, 32'h0002, 4'd4, 1, 3, 0, 1, "R5 dword at 2");
    drive(1, 32'h0008, 4'd4, 1, 3, 0, 1, "R5 dword at 8");
    drive(1, 32'h0006, 4'd8, 1, 3, 0, 1, "R5 pseudo-descriptor at 6");
    drive(1, 32'h0004, 4'd10, 1, 3, 0, 1, "R6 double at 4");
    drive(1, 32'h0010, 4'd11, 1, 3, 0, 1, "R6 extended at 16");
    drive(1, 32'h0002, 4'd12, 1, 3, 0, 1, "R7 env 32-bit at 2");
    drive(1, 32'h0002, 4'd12, 0, 3, 0, 1, "R7 env 16-bit at 2");
    drive(1, 32'h0001, 4'd13, 0, 3, 0, 1, "R7 fpu state 16-bit odd");
    drive(1, 32'h0007, 4'd0, 1, 3, 0, 1, "R8 byte at 7");
    drive(1, 32'h0007, 4'd14, 1, 3, 0, 1, "R8 unused 14");
    drive(1, 32'h0007, 4'd15, 1, 3, 0, 1, "R8 unused 15");
    drive(1, 32'h0001, 4'd4, 1, 3, 0, 0, "R1 enable off");
    for (int p = 0; p < 3; p++)
      drive(1, 32'h0003, 4'd10, 1, p[1:0], 0, 1, "R2 privilege below 3");
    drive(1, 32'h0003, 4'd6, 1, 3, 1, 1, "R3 implicit supervisor");
    drive(0, 32'h0001, 4'd4, 1, 3, 0, 1, "R9 invalid request");
    drive(1, 32'h0001, 4'd4, 1, 3, 0, 1, "R9 back-to-back A");
    drive(1, 32'h0003, 4'd5, 1, 3, 0, 1, "R9 back-to-back B");
    drive(0, 32'h0000, 4'd0, 1, 3, 0, 1, "R9 pulse ends R10 vector cleared");

    for (int o = 0; o < 2; o++)
      for (int t = 0; t < 16; t++)
        for (int a = 0; a < 8; a++)
          drive(1, 32'hA000 + a, t[3:0], o[0], 3, 0, 1, "R4 R5 R6 R7 R8 sweep");
    drive(0, 32'h0, 4'd0, 1, 3, 0, 1, "R9 idle tail");
    repeat (3) @(negedge clk);

    drive(1, 32'h0001, 4'd1, 1, 3, 0, 1, "R11 pending");
    void'(sb.pop_back());
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    compare(1'b0, "R11 reset overrides pending fault");
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule